// File: doc/BRIEF.md
# Open-Drain Line Repeater with Edge Arbitration

This block joins a host-side data line and a card-side data line, both of the open-drain kind, so that a low placed on either one appears on the other. Every line is seen by the block as three signals: a sensed level coming in, an enable for a strong pull to low going out, and an enable for a short strong push to high going out. The host line keeps its weak pull-up at all times. The card line is parked low whenever the session enable from the power sequencer is off.

The first line to fall becomes master. Falling edges on the other line are then ignored, and that line acts only as slave. After a fixed delay the slave is pulled low. When the master goes high again, the slave pull is released and a strong push to high is applied for one delay period. The pair is then left on weak pull-ups until both lines read high, and only then can a new master be chosen.

The delay is a number of system clock cycles. It is derived from the clock frequency and a nanosecond target, rounded up, so line rates up to 1 MHz are carried. A larger design uses three copies of this block: one for the data line and two for auxiliary lines.

Top module: `io_repeater`

## Requirements
- R1: When the session enable is low, and out of reset, no pull-low or push-high output is active and `card_park_low` is 1. While the enable is high, `card_park_low` is 0.
- R2: Let the host line fall while both lines are idle high. `card_pull_low` then rises exactly DLY+3 clock edges after the change: two synchronizer stages, one decision edge and DLY delay cycles. DLY = ceil(DELAY_NS*CLK_HZ/1e9), and at least 1. It is 40 at the default 200 MHz and 200 ns.
- R3: The same holds with the sides swapped. When the card line falls first, `host_pull_low` rises DLY+3 edges later.
- R4: While one side is master, the pull-low on the master side stays 0. This holds even if the slave line is driven low and released from outside.
- R5: Three edges after the master line returns high, the slave pull-low releases. On that same cycle the slave push-high asserts, and it stays on for exactly DLY cycles.
- R6: After the push-high pulse ends, all drivers are off. A new falling edge is then arbitrated normally, with the same latency.
- R7: When both lines fall in the same clock cycle, the host side is master and the card side is pulled low.
- R8: Dropping the enable turns off every pull and push output in that same cycle, with no clock edge needed. It also returns arbitration to idle, so a line that is still held low when the enable comes back is not repeated.
- R9: A master low pulse that ends before the delay has run out causes no pull-low and no push-high on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| en | input | 1 | Session enable from the sequencer |
| host_in | input | 1 | Sensed host-side line level |
| card_in | input | 1 | Sensed card-side line level |
| host_pull_low | output | 1 | Strong low drive on host line |
| host_push_high | output | 1 | Brief strong high drive on host line |
| card_pull_low | output | 1 | Strong low drive on card line |
| card_push_high | output | 1 | Brief strong high drive on card line |
| card_park_low | output | 1 | Holds card line low outside a session |

## Verification
The hardest case to create is a slave line that moves while it is already being held low by the block. In that state the anti-latch must keep the master side from being pulled. The bench models both lines as wired-AND, combining its own drivers with the block's pull outputs. During the hold phase of a host-led transfer it drives the card line low from outside and then releases it, and it checks that the host pull never asserts. Random transfers vary the master side, the hold length and the gaps between transfers. Directed cases cover simultaneous falls, pulses too short to be repeated, and the enable being cut in mid-transfer.

// File: rtl/io_repeater.sv
module io_repeater #(
  parameter int unsigned CLK_HZ   = 200_000_000,
  parameter int unsigned DELAY_NS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic host_in,
  input  logic card_in,
  output logic host_pull_low,
  output logic host_push_high,
  output logic card_pull_low,
  output logic card_push_high,
  output logic card_park_low
);
  localparam longint unsigned PROD = longint'(DELAY_NS) * longint'(CLK_HZ);
  localparam longint unsigned RAW  = (PROD + 64'd999_999_999) / 64'd1_000_000_000;
  localparam int unsigned DLY = (RAW < 1) ? 1 : int'(RAW);
  localparam int CW = $clog2(DLY + 1);

  typedef enum logic [2:0] {IDLE, WAIT, HOLD, PUSH, SETTLE} phase_t;

  logic [1:0] h_sync, c_sync;
  logic h_q, c_q;
  logic h_s, c_s;
  logic fall_h, fall_c;
  logic card_master;
  logic m_hi;
  logic last;
  phase_t phase;
  logic [CW-1:0] cnt;

  assign h_s    = h_sync[1];
  assign c_s    = c_sync[1];
  assign fall_h = h_q & ~h_s;
  assign fall_c = c_q & ~c_s;
  assign m_hi   = card_master ? c_s : h_s;
  assign last   = (cnt == CW'(DLY - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_sync <= 2'b11;
      c_sync <= 2'b11;
      h_q    <= 1'b1;
      c_q    <= 1'b1;
    end else begin
      h_sync <= {h_sync[0], host_in};
      c_sync <= {c_sync[0], card_in};
      h_q    <= h_s;
      c_q    <= c_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= IDLE;
      cnt         <= '0;
      card_master <= 1'b0;
    end else if (!en) begin
      phase       <= IDLE;
      cnt         <= '0;
      card_master <= 1'b0;
    end else begin
      case (phase)
        IDLE: begin
          cnt <= '0;
          if (fall_h) begin
            card_master <= 1'b0;
            phase       <= WAIT;
          end else if (fall_c) begin
            card_master <= 1'b1;
            phase       <= WAIT;
          end
        end
        WAIT: begin
          if (m_hi) begin
            phase <= SETTLE;
            cnt   <= '0;
          end else if (last) begin
            phase <= HOLD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        HOLD: begin
          if (m_hi) begin
            phase <= PUSH;
            cnt   <= '0;
          end
        end
        PUSH: begin
          if (last) begin
            phase <= SETTLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        SETTLE: begin
          if (h_s && c_s) phase <= IDLE;
        end
        default: phase <= IDLE;
      endcase
    end
  end

  assign card_pull_low  = en && (phase == HOLD) && !card_master;
  assign host_pull_low  = en && (phase == HOLD) &&  card_master;
  assign card_push_high = en && (phase == PUSH) && !card_master;
  assign host_push_high = en && (phase == PUSH) &&  card_master;
  assign card_park_low  = !en;
endmodule

module io_repeater_chk #(
  parameter int unsigned CLK_HZ   = 200_000_000,
  parameter int unsigned DELAY_NS = 200
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic host_pull_low,
  input logic host_push_high,
  input logic card_pull_low,
  input logic card_push_high,
  input logic card_park_low
);
  localparam longint unsigned PROD = longint'(DELAY_NS) * longint'(CLK_HZ);
  localparam longint unsigned RAW  = (PROD + 64'd999_999_999) / 64'd1_000_000_000;
  localparam int unsigned DLY = (RAW < 1) ? 1 : int'(RAW);

  logic any_push;
  int unsigned push_cnt;
  assign any_push = host_push_high | card_push_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) push_cnt <= 0;
    else if (any_push) push_cnt <= push_cnt + 1;
    else push_cnt <= 0;
  end

  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (card_park_low && !host_pull_low && !card_pull_low && !host_push_high && !card_push_high));

  assert_single_slave_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_pull_low && card_pull_low) && !(host_push_high && card_push_high));

  assert_no_drive_fight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_pull_low && host_push_high) && !(card_pull_low && card_push_high));

  assert_push_after_pull_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $fell(card_pull_low)) |-> card_push_high);

  assert_push_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $fell(any_push)) |-> (push_cnt == DLY));

  assert_push_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_cnt <= DLY);

  assert_quiet_after_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $fell(any_push)) |=> (!host_pull_low && !card_pull_low));
endmodule

bind io_repeater io_repeater_chk #(.CLK_HZ(CLK_HZ), .DELAY_NS(DELAY_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en),
  .host_pull_low(host_pull_low), .host_push_high(host_push_high),
  .card_pull_low(card_pull_low), .card_push_high(card_push_high),
  .card_park_low(card_park_low)
);

// File: tb/io_repeater_bench.sv
module io_repeater_bench;
  localparam int unsigned CLK_HZ   = 200_000_000;
  localparam int unsigned DELAY_NS = 200;

  function automatic int exp_dly();
    longint p = longint'(DELAY_NS) * longint'(CLK_HZ);
    longint d = (p + 999_999_999) / 1_000_000_000;
    return (d < 1) ? 1 : int'(d);
  endfunction

  localparam int D = exp_dly();

  logic clk = 0, rst_n = 0, en = 0;
  logic h_ext = 0, c_ext = 0;
  logic host_pull_low, host_push_high, card_pull_low, card_push_high, card_park_low;
  logic host_in, card_in;
  int errors = 0, checks = 0;
  bit done = 0;

  assign host_in = !(h_ext | host_pull_low);
  assign card_in = !(c_ext | card_pull_low | card_park_low);

  always #2.5 clk = ~clk;

  io_repeater #(.CLK_HZ(CLK_HZ), .DELAY_NS(DELAY_NS)) u_io_repeater (
    .clk(clk), .rst_n(rst_n), .en(en), .host_in(host_in), .card_in(card_in),
    .host_pull_low(host_pull_low), .host_push_high(host_push_high),
    .card_pull_low(card_pull_low), .card_push_high(card_push_high),
    .card_park_low(card_park_low)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int drv_bits();
    return {host_pull_low, host_push_high, card_pull_low, card_push_high};
  endfunction

  task automatic settle();
    repeat (8) @(negedge clk);
    check(drv_bits() == 0, "R6 idle drivers", drv_bits(), 0);
  endtask

  task automatic xact(input bit hd, input bit cd, input int hold, input bit poke, input string tag);
    bit hm = hd;
    int lat = -1, rel = -1, wid = 0, k;
    bit bad = 0, push_at_rel = 0;
    @(negedge clk); h_ext = hd; c_ext = cd;
    for (k = 1; k <= hold; k++) begin
      @(negedge clk);
      if (lat < 0 && (hm ? card_pull_low : host_pull_low)) lat = k;
      if (hm ? host_pull_low : card_pull_low) bad = 1;
      if (poke && k == D + 8)  begin if (hm) c_ext = 1; else h_ext = 1; end
      if (poke && k == D + 14) begin if (hm) c_ext = 0; else h_ext = 0; end
    end
    check(lat == D + 3, tag, lat, D + 3);
    check(!bad, "R4 master side stays undriven", bad, 0);
    h_ext = 0; c_ext = 0;
    for (k = 1; k <= 20 && rel < 0; k++) begin
      @(negedge clk);
      if (!(hm ? card_pull_low : host_pull_low)) begin
        rel = k;
        push_at_rel = hm ? card_push_high : host_push_high;
      end
    end
    check(rel == 3, "R5 release latency", rel, 3);
    check(push_at_rel, "R5 push starts with release", push_at_rel, 1);
    wid = push_at_rel ? 1 : 0;
    for (k = 0; k < 4 * D && (hm ? card_push_high : host_push_high); k++) begin
      @(negedge clk);
      if (hm ? card_push_high : host_push_high) wid++;
    end
    check(wid == D, "R5 push width", wid, D);
    settle();
  endtask

  task automatic short_pulse(input bit side_host, input int h);
    bit any = 0;
    @(negedge clk); if (side_host) h_ext = 1; else c_ext = 1;
    repeat (h) @(negedge clk);
    h_ext = 0; c_ext = 0;
    repeat (2 * D + 10) begin
      @(negedge clk);
      if (drv_bits() != 0) any = 1;
    end
    check(!any, "R9 short pulse not repeated", any, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(drv_bits() == 0, "R1 reset drivers", drv_bits(), 0);
    check(card_park_low == 1, "R1 reset park", card_park_low, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(card_park_low == 1 && drv_bits() == 0, "R1 disabled", card_park_low, 1);
    en = 1;
    #1 check(card_park_low == 0, "R1 park released", card_park_low, 0);
    repeat (5) @(negedge clk);

    xact(1, 0, D + 30, 0, "R2 host-led latency");
    xact(0, 1, D + 30, 0, "R3 card-led latency");
    xact(1, 1, D + 30, 0, "R7 simultaneous host wins");
    xact(1, 0, D + 40, 1, "R2 host-led with slave poke");
    xact(0, 1, D + 40, 1, "R3 card-led with slave poke");
    short_pulse(1, 1);
    short_pulse(0, D - 2);

    // R8: cut enable during hold
    @(negedge clk); h_ext = 1;
    repeat (D + 10) @(negedge clk);
    check(card_pull_low == 1, "R8 pre-cut hold", card_pull_low, 1);
    #1 en = 0;
    #1 check(drv_bits() == 0, "R8 immediate release", drv_bits(), 0);
    check(card_park_low == 1, "R8 park on cut", card_park_low, 1);
    repeat (5) @(negedge clk);
    en = 1;
    begin
      bit any = 0;
      repeat (2 * D + 10) begin
        @(negedge clk);
        if (drv_bits() != 0) any = 1;
      end
      check(!any, "R8 held line not repeated after re-enable", any, 0);
    end
    h_ext = 0;
    settle();
    xact(1, 0, D + 25, 0, "R6 normal after cut");

    for (int i = 0; i < 24; i++) begin
      int sel = $urandom_range(0, 9);
      repeat ($urandom_range(0, 15)) @(negedge clk);
      if (sel < 4)      xact(1, 0, D + 20 + $urandom_range(0, 60), sel[0], "R2 random host-led");
      else if (sel < 8) xact(0, 1, D + 20 + $urandom_range(0, 60), sel[0], "R3 random card-led");
      else if (sel < 9) xact(1, 1, D + 20 + $urandom_range(0, 40), 0, "R7 random simultaneous");
      else              short_pulse($urandom_range(0, 1) == 1, $urandom_range(1, D - 2));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule